// File: doc/BRIEF.md
# Dual-Edge Watchdog Timer with Startup Window

This block supervises a software or firmware heartbeat. Any change of level on the kick input, rising or falling, restarts the supervision window. If the kick input stays at one level for longer than the run window, the block sends a one-cycle expiry pulse to the chip's reset controller. The reset controller reports back through a reset-active input. While that input is high, the timer is held cleared. Once it drops, the block opens a much longer startup window, which gives the boot code time to make its first kick.

The kick input is asynchronous. It passes through a synchroniser chain before the edge detector, so a kick pulse has to last at least one clock period to be seen reliably. An enable input stands in for the "input left floating" condition. While enable is low the watchdog is inert. When enable returns high, the watchdog starts again in the startup window. Both windows are given in clock cycles as parameters.

Top module: `wdg_dual_edge`

## Requirements
- R1: While rst_ni is low, and afterwards until an expiry condition is reached, expire_o stays low.
- R2: Both a rising and a falling edge on kick_i count as a kick. A kick pulse that is high for a single clock cycle produces two kicks, and the later edge sets the window.
- R3: With no kick, expire_o pulses exactly STARTUP_CYC+1 cycles after the negedge on which sys_rst_active_i was driven low.
- R4: Suppose a kick edge is driven on kick_i at cycle c and no further kick follows. Then expire_o pulses at cycle c+SYNC_STAGES+1+TIMEOUT_CYC. A further kick driven no more than TIMEOUT_CYC cycles after the previous one prevents that pulse.
- R5: While sys_rst_active_i is high, no pulse is produced, the timer is cleared and kicks are ignored. When sys_rst_active_i is released, a new startup window (R3) opens, even if the block was in the run window before the reset.
- R6: Every pulse on expire_o lasts exactly one clock cycle.
- R7: After an expiry, with sys_rst_active_i low, the block opens a new startup window on the following cycle. The next pulse comes STARTUP_CYC+1 cycles after the previous one.
- R8: While enable_i is low, expire_o never pulses, whatever kick_i does.
- R9: When enable_i is driven high at cycle c, a startup window opens, and without a kick the pulse comes at c+STARTUP_CYC+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Asynchronous heartbeat; every edge is a kick |
| enable_i | input | 1 | Watchdog active when high |
| sys_rst_active_i | input | 1 | High while the reset controller holds the system in reset |
| expire_o | output | 1 | One-cycle request for a system reset |

## Verification
The bench sweeps the gap between two kicks from one cycle to past the run window. It checks that a gap of exactly TIMEOUT_CYC still saves the system, and that a gap one cycle longer does not. A design that compared against the wrong limit would fire a cycle early or a cycle late. A one-cycle kick pulse is used to show that the falling edge counts as well: a rising-only detector would fire one cycle early. The bench also drops the reset-active input in the middle of the run window and checks that the long startup window follows, which catches a timer that keeps its old count. Expiry without any reset must open a fresh startup window, and re-enabling must do the same; a block that stalled in its wait state would never fire again.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  typedef enum logic [1:0] {
    WDG_OFF   = 2'd0,
    WDG_START = 2'd1,
    WDG_RUN   = 2'd2,
    WDG_HOLD  = 2'd3
  } wdg_state_e;
endpackage

// File: rtl/wdg_kick_sync.sv
`timescale 1ns/1ps
module wdg_kick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], kick_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  // either direction of change is a kick
  assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/wdg_timer.sv
`timescale 1ns/1ps
module wdg_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/wdg_ctrl.sv
`timescale 1ns/1ps
module wdg_ctrl
  import wdg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       sys_rst_i,
  input  logic       kick_edge_i,
  input  logic       hit_i,
  output wdg_state_e state_o,
  output logic       clear_o,
  output logic       inc_o,
  output logic       expire_o
);
  wdg_state_e state_q, state_d;
  logic       expire_q, expire_d;

  always_comb begin
    state_d  = state_q;
    clear_o  = 1'b0;
    inc_o    = 1'b0;
    expire_d = 1'b0;
    if (!enable_i) begin
      state_d = WDG_OFF;
      clear_o = 1'b1;
    end else if (sys_rst_i) begin
      state_d = WDG_HOLD;
      clear_o = 1'b1;
    end else begin
      unique case (state_q)
        WDG_OFF, WDG_HOLD: begin
          state_d = WDG_START;
          clear_o = 1'b1;
        end
        WDG_START, WDG_RUN: begin
          if (kick_edge_i) begin
            state_d = WDG_RUN;
            clear_o = 1'b1;
          end else if (hit_i) begin
            state_d  = WDG_HOLD;
            clear_o  = 1'b1;
            expire_d = 1'b1;
          end else begin
            inc_o = 1'b1;
          end
        end
        default: begin
          state_d = WDG_OFF;
          clear_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= WDG_OFF;
      expire_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      expire_q <= expire_d;
    end
  end

  assign state_o  = state_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/wdg_dual_edge.sv
`timescale 1ns/1ps
module wdg_dual_edge
  import wdg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT_CYC = 1_600_000,
  parameter int unsigned STARTUP_CYC = 54_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic enable_i,
  input  logic sys_rst_active_i,
  output logic expire_o
);
  localparam int unsigned MAX_CYC = (STARTUP_CYC > TIMEOUT_CYC) ? STARTUP_CYC : TIMEOUT_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] START_LIM = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] RUN_LIM   = CW'(TIMEOUT_CYC - 1);

  logic       kick_edge;
  logic       hit, clear, inc;
  wdg_state_e state_q;
  logic [CW-1:0] limit;

  wdg_kick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  assign limit = (state_q == WDG_START) ? START_LIM : RUN_LIM;

  wdg_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .inc_i   (inc),
    .limit_i (limit),
    .hit_o   (hit)
  );

  wdg_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .sys_rst_i   (sys_rst_active_i),
    .kick_edge_i (kick_edge),
    .hit_i       (hit),
    .state_o     (state_q),
    .clear_o     (clear),
    .inc_o       (inc),
    .expire_o    (expire_o)
  );
endmodule

// File: rtl/wdg_dual_edge_chk.sv
`timescale 1ns/1ps
module wdg_dual_edge_chk
  import wdg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       sys_rst_active_i,
  input logic       kick_edge,
  input logic       expire_o,
  input wdg_state_e state
);
  AST_EXP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R6
  AST_NO_EXP_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !expire_o); // R8
  AST_NO_EXP_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_active_i |=> !expire_o); // R5
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !sys_rst_active_i && kick_edge && state == WDG_RUN) |=> !expire_o); // R4
  AST_EXP_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> state == WDG_HOLD); // R7
  AST_HOLD_TO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == WDG_HOLD && enable_i && !sys_rst_active_i) |=> state == WDG_START); // R7
endmodule

bind wdg_dual_edge wdg_dual_edge_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enable_i         (enable_i),
  .sys_rst_active_i (sys_rst_active_i),
  .kick_edge        (kick_edge),
  .expire_o         (expire_o),
  .state            (state_q)
);

// File: tb/wdg_dual_edge_tb.sv
`timescale 1ns/1ps
module wdg_dual_edge_tb;
  localparam int SYNC = 2;
  localparam int T    = 12;
  localparam int S    = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0;
  logic en = 1'b1;
  logic srst = 1'b1;
  logic expire;

  int cyc = 0;
  int exp_cnt = 0;
  int last_exp = -1;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wdg_dual_edge #(.SYNC_STAGES(SYNC), .TIMEOUT_CYC(T), .STARTUP_CYC(S)) u_dut (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .kick_i           (kick),
    .enable_i         (en),
    .sys_rst_active_i (srst),
    .expire_o         (expire)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (expire) begin
      exp_cnt  <= exp_cnt + 1;
      last_exp <= cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic restart(output int c0, output int snap);
    @(negedge clk);
    srst <= 1'b1;
    repeat (3) @(negedge clk);
    srst <= 1'b0;
    c0   = cyc;
    snap = exp_cnt;
  endtask

  task automatic flip();
    kick <= ~kick;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog hung act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0, c1, snap, e;
    int quiet;
    // R1: quiet under and right after reset
    quiet = 0;
    repeat (4) begin
      @(negedge clk);
      if (expire) quiet++;
    end
    rst_n <= 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (expire) quiet++;
    end
    chk(quiet == 0, "R1 reset quiet", quiet, 0);

    // R3 startup window, R6 width, R7 auto restart
    restart(c0, snap);
    wait_until(c0 + S + 2);
    chk(exp_cnt - snap == 1, "R3 startup pulse count", exp_cnt - snap, 1);
    chk(last_exp == c0 + S + 1, "R3 startup expiry cycle", last_exp - c0, S + 1);
    chk(expire == 1'b0, "R6 pulse one cycle", int'(expire), 0);
    wait_until(c0 + 2*S + 3);
    chk(exp_cnt - snap == 2, "R7 restart pulse count", exp_cnt - snap, 2);
    chk(last_exp == c0 + 2*S + 2, "R7 next startup cycle", last_exp - c0, 2*S + 2);

    // R4 kick during startup switches to run window
    restart(c0, snap);
    wait_until(c0 + 10);
    flip();
    e = c0 + 10 + SYNC + 1 + T;
    wait_until(e + 1);
    chk(exp_cnt - snap == 1, "R4 run pulse count", exp_cnt - snap, 1);
    chk(last_exp == e, "R4 run expiry cycle", last_exp - c0, e - c0);

    // R2/R4 sweep of kick gap, edges alternate direction
    for (int d = 1; d <= T + 3; d++) begin
      restart(c0, snap);
      flip();
      wait_until(c0 + d);
      flip();
      e = (d <= T) ? c0 + d + SYNC + 1 + T : c0 + SYNC + 1 + T;
      wait_until(e + 1);
      chk(exp_cnt - snap == 1, $sformatf("R4 gap %0d count", d), exp_cnt - snap, 1);
      chk(last_exp == e, $sformatf("R2 R4 gap %0d expiry", d), last_exp - c0, e - c0);
    end

    // R5 held reset: no expiry, kicks ignored, startup on release
    @(negedge clk);
    srst <= 1'b1;
    snap = exp_cnt;
    for (int i = 0; i < 3*S; i++) begin
      @(negedge clk);
      if (i % 5 == 0 && i < 3*S - 5) flip();
    end
    chk(exp_cnt == snap, "R5 no expiry in reset", exp_cnt - snap, 0);
    srst <= 1'b0;
    c0 = cyc;
    wait_until(c0 + S + 2);
    chk(last_exp == c0 + S + 1 && exp_cnt - snap == 1, "R5 startup after release",
        last_exp - c0, S + 1);

    // R5 reset in the middle of the run window clears the timer
    restart(c0, snap);
    flip();
    wait_until(c0 + 8);
    srst <= 1'b1;
    wait_until(c0 + 10);
    srst <= 1'b0;
    c1 = cyc;
    wait_until(c1 + S + 2);
    chk(exp_cnt - snap == 1, "R5 mid-run count", exp_cnt - snap, 1);
    chk(last_exp == c1 + S + 1, "R5 mid-run expiry", last_exp - c1, S + 1);

    // R8 disabled: never expires; R9 re-enable opens startup
    restart(c0, snap);
    en <= 1'b0;
    for (int i = 0; i < 3*S; i++) begin
      @(negedge clk);
      if (i % 7 == 0 && i < 3*S - 5) flip();
    end
    chk(exp_cnt == snap, "R8 disabled quiet", exp_cnt - snap, 0);
    chk(expire == 1'b0, "R8 output low", int'(expire), 0);
    en <= 1'b1;
    c0 = cyc;
    wait_until(c0 + S + 2);
    chk(last_exp == c0 + S + 1 && exp_cnt - snap == 1, "R9 enable startup",
        last_exp - c0, S + 1);

    // R2 one-cycle kick pulse: both edges count
    restart(c0, snap);
    wait_until(c0 + 5);
    flip();
    wait_until(c0 + 6);
    flip();
    e = c0 + 6 + SYNC + 1 + T;
    wait_until(e + 1);
    chk(exp_cnt - snap == 1, "R2 short pulse count", exp_cnt - snap, 1);
    chk(last_exp == e, "R2 short pulse falling edge", last_exp - c0, e - c0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule